// File: doc/BRIEF.md
# Paged RAM Bank Mapper

This block holds the page registers of a RAM bank mapper for an 8-bit CPU with a 64K address space. The space is cut into four 16K pages. Each page has its own 8-bit register, and that register names the 16K bank of physical RAM that the page shows. On every memory cycle the block forms a physical address. The bank held for the page being accessed supplies the upper bits, and the low 14 CPU address bits pass through unchanged. With eight bank bits this covers 256 banks, or 4MB of RAM.

The CPU programs the registers through a window of four I/O ports, 0xFC to 0xFF. Port 0xFC selects page 0 and port 0xFF selects page 3. Only the low address byte is decoded. The window is common to every mapper in the system, so a write lands whatever the external slot enable says, and all mappers are retargeted together. The slot enable only qualifies the RAM chip select on memory cycles.

An I/O read in the window returns the stored bank number. In a build with fewer bank bits, the unimplemented upper bits read back as ones. Bus strobes are active low and are sampled on the rising clock edge. Reset is synchronous and active high.

Top module: `mmap_top`

## Requirements
- R1: After reset, the registers of pages 0, 1, 2 and 3 hold banks 3, 2, 1 and 0.
- R2: An I/O write (iorq_n=0, wr_n=0) to port 0xFC+p stores cpu_din in the register of page p on that clock edge. The other three registers keep their values.
- R3: ram_addr is {bank of page cpu_addr[15:14], cpu_addr[13:0]}, computed combinationally from the current register values.
- R4: Only cpu_addr[7:0] is decoded for the port match; any value of cpu_addr[15:8] still writes.
- R5: Register writes take effect whatever the level of slot_en.
- R6: No register changes unless iorq_n and wr_n are both 0 and cpu_addr[7:2] equals 6'b111111.
- R7: When iorq_n=0, rd_n=0 and cpu_addr[7:0] is in 0xFC..0xFF, rd_oe is 1 and rd_data holds the register of page cpu_addr[1:0]. Otherwise rd_oe is 0.
- R8: ram_cs is 1 exactly when mreq_n=0 and slot_en=1.
- R9: With BANK_W below 8, only the low BANK_W bits of a write are stored, ram_addr is BANK_W+14 bits wide, and rd_data bits above BANK_W-1 read as 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_addr | input | 16 | CPU address bus |
| cpu_din | input | 8 | CPU write data |
| iorq_n | input | 1 | I/O request, active low |
| mreq_n | input | 1 | Memory request, active low |
| rd_n | input | 1 | Read strobe, active low |
| wr_n | input | 1 | Write strobe, active low |
| slot_en | input | 1 | Slot qualification from the slot decoder |
| ram_addr | output | BANK_W+14 | Physical RAM address |
| ram_cs | output | 1 | RAM chip select |
| rd_data | output | 8 | Register readback data |
| rd_oe | output | 1 | Readback data valid / drive enable |

## Verification
The bench writes the window with random upper address bytes and with slot_en low. A mapper that decoded all 16 bits, or gated writes by slot, would leave its banks stale. Near-miss accesses (port 0xFB, port 0x7C, I/O without a write strobe, a write strobe without IORQ) must leave every page untouched. A loose decoder would corrupt a bank there, and the bench sees the corruption through the translated address. A second instance with five bank bits checks truncation of stored values and the ones-padding on readback. A zero-padded or untruncated build shows up as wrong rd_data or ram_addr.

// File: rtl/mmap_pkg.sv
package mmap_pkg;

    localparam int CPU_AW      = 16;
    localparam int PAGE_OFS_W  = 14;
    localparam int PAGE_IDX_W  = CPU_AW - PAGE_OFS_W;
    localparam int PAGE_CNT    = 1 << PAGE_IDX_W;
    localparam int DATA_W      = 8;
    localparam int PORT_LSB_W  = PAGE_IDX_W;
    localparam logic [DATA_W-1:0] PORT_BASE = 8'hFC;

    typedef logic [PAGE_IDX_W-1:0] page_idx_t;

    typedef struct packed {
        logic      hit;
        logic      wr;
        logic      rd;
        page_idx_t page;
    } io_dec_t;

    function automatic logic [DATA_W-1:0] reset_bank(input int unsigned page);
        return DATA_W'(PAGE_CNT - 1 - page);
    endfunction

    function automatic logic [DATA_W-1:0] pad_ones(input logic [DATA_W-1:0] v,
                                                   input int unsigned used_w);
        logic [DATA_W-1:0] fill;
        fill = (used_w >= DATA_W) ? '0 : ({DATA_W{1'b1}} << used_w);
        return v | fill;
    endfunction

endpackage

// File: rtl/mmap_io_decode.sv
module mmap_io_decode
    import mmap_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic [CPU_AW-1:0]    cpu_addr,
    input  logic                 iorq_n,
    input  logic                 rd_n,
    input  logic                 wr_n,
    output io_dec_t              dec,
    output logic [PAGE_CNT-1:0]  page_we
);

    logic port_hit;

    always_comb begin
        port_hit = (cpu_addr[DATA_W-1:PORT_LSB_W] == PORT_BASE[DATA_W-1:PORT_LSB_W]);
        dec.hit  = port_hit & ~iorq_n;
        dec.wr   = ~wr_n;
        dec.rd   = ~rd_n;
        dec.page = cpu_addr[PORT_LSB_W-1:0];
    end

    for (genvar p = 0; p < PAGE_CNT; p++) begin : g_we
        assign page_we[p] = dec.hit & dec.wr & (dec.page == page_idx_t'(p));
    end

    // R2: a write never targets more than one page
    p_single_page_r2: assert property (@(posedge clk) disable iff (rst)
        $onehot0(page_we));

    // R6: a write strobe needs both IORQ and WR active
    p_we_needs_strobes_r6: assert property (@(posedge clk) disable iff (rst)
        (|page_we) |-> (!iorq_n && !wr_n));

endmodule

// File: rtl/mmap_bank_regs.sv
module mmap_bank_regs
    import mmap_pkg::*;
#(
    parameter int BANK_W = 8
) (
    input  logic                              clk,
    input  logic                              rst,
    input  logic [PAGE_CNT-1:0]               page_we,
    input  logic [DATA_W-1:0]                 wdata,
    output logic [PAGE_CNT-1:0][BANK_W-1:0]   bank_q
);

    for (genvar p = 0; p < PAGE_CNT; p++) begin : g_page
        localparam logic [DATA_W-1:0] RST_FULL = reset_bank(p);
        localparam logic [BANK_W-1:0] RST_VAL  = RST_FULL[BANK_W-1:0];

        always_ff @(posedge clk) begin
            if (rst)
                bank_q[p] <= RST_VAL;
            else if (page_we[p])
                bank_q[p] <= wdata[BANK_W-1:0];
        end

        // R2: written value appears on the next cycle
        p_write_lands_r2: assert property (@(posedge clk) disable iff (rst)
            page_we[p] |=> (bank_q[p] == $past(wdata[BANK_W-1:0])));

        // R6: without a write enable the page register holds
        p_hold_r6: assert property (@(posedge clk) disable iff (rst)
            !page_we[p] |=> $stable(bank_q[p]));
    end

endmodule

// File: rtl/mmap_addr_xlate.sv
module mmap_addr_xlate
    import mmap_pkg::*;
#(
    parameter int BANK_W = 8,
    localparam int PHYS_W = BANK_W + PAGE_OFS_W
) (
    input  logic [CPU_AW-1:0]               cpu_addr,
    input  logic                            mreq_n,
    input  logic                            slot_en,
    input  logic [PAGE_CNT-1:0][BANK_W-1:0] bank_q,
    output logic [PHYS_W-1:0]               ram_addr,
    output logic                            ram_cs
);

    page_idx_t         page;
    logic [BANK_W-1:0] bank_sel;

    always_comb begin
        page     = cpu_addr[CPU_AW-1:PAGE_OFS_W];
        bank_sel = bank_q[page];
        ram_addr = {bank_sel, cpu_addr[PAGE_OFS_W-1:0]};
        ram_cs   = ~mreq_n & slot_en;
    end

endmodule

// File: rtl/mmap_readback.sv
module mmap_readback
    import mmap_pkg::*;
#(
    parameter int BANK_W = 8
) (
    input  io_dec_t                         dec,
    input  logic [PAGE_CNT-1:0][BANK_W-1:0] bank_q,
    output logic [DATA_W-1:0]               rd_data,
    output logic                            rd_oe
);

    logic [DATA_W-1:0] raw;

    always_comb begin
        raw     = DATA_W'(bank_q[dec.page]);
        rd_data = pad_ones(raw, BANK_W);
        rd_oe   = dec.hit & dec.rd;
    end

endmodule

// File: rtl/mmap_top.sv
module mmap_top
    import mmap_pkg::*;
#(
    parameter int BANK_W = 8,
    localparam int PHYS_W = BANK_W + PAGE_OFS_W
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [15:0]        cpu_addr,
    input  logic [7:0]         cpu_din,
    input  logic               iorq_n,
    input  logic               mreq_n,
    input  logic               rd_n,
    input  logic               wr_n,
    input  logic               slot_en,
    output logic [PHYS_W-1:0]  ram_addr,
    output logic               ram_cs,
    output logic [7:0]         rd_data,
    output logic               rd_oe
);

    io_dec_t                         dec;
    logic [PAGE_CNT-1:0]             page_we;
    logic [PAGE_CNT-1:0][BANK_W-1:0] bank_q;

    mmap_io_decode u_dec (
        .clk      (clk),
        .rst      (rst),
        .cpu_addr (cpu_addr),
        .iorq_n   (iorq_n),
        .rd_n     (rd_n),
        .wr_n     (wr_n),
        .dec      (dec),
        .page_we  (page_we)
    );

    mmap_bank_regs #(.BANK_W(BANK_W)) u_regs (
        .clk     (clk),
        .rst     (rst),
        .page_we (page_we),
        .wdata   (cpu_din),
        .bank_q  (bank_q)
    );

    mmap_addr_xlate #(.BANK_W(BANK_W)) u_xlate (
        .cpu_addr (cpu_addr),
        .mreq_n   (mreq_n),
        .slot_en  (slot_en),
        .bank_q   (bank_q),
        .ram_addr (ram_addr),
        .ram_cs   (ram_cs)
    );

    mmap_readback #(.BANK_W(BANK_W)) u_rb (
        .dec     (dec),
        .bank_q  (bank_q),
        .rd_data (rd_data),
        .rd_oe   (rd_oe)
    );

    // R3: bank field of the physical address follows the page register
    p_bank_field_r3: assert property (@(posedge clk) disable iff (rst)
        ram_addr[PHYS_W-1:PAGE_OFS_W] == bank_q[cpu_addr[15:14]]);

    // R7: readback returns the register chosen by the port offset
    p_readback_match_r7: assert property (@(posedge clk) disable iff (rst)
        rd_oe |-> (rd_data[BANK_W-1:0] == bank_q[cpu_addr[1:0]]));

    // R8: chip select only on a qualified memory cycle
    p_cs_qualified_r8: assert property (@(posedge clk) disable iff (rst)
        ram_cs |-> (!mreq_n && slot_en));

endmodule

// File: tb/mmap_top_tb_top.sv
`timescale 1ns/1ps
module mmap_top_tb_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [15:0] cpu_addr = '0;
    logic [7:0]  cpu_din = '0;
    logic        iorq_n = 1'b1, mreq_n = 1'b1, rd_n = 1'b1, wr_n = 1'b1, slot_en = 1'b0;

    logic [21:0] ram_addr;
    logic        ram_cs, rd_oe;
    logic [7:0]  rd_data;
    logic [18:0] ram_addr5;
    logic        ram_cs5, rd_oe5;
    logic [7:0]  rd_data5;

    int checks = 0;
    int errors = 0;
    logic [7:0] mdl [4];

    always #2.5 clk = ~clk;

    mmap_top dut_i (
        .clk(clk), .rst(rst), .cpu_addr(cpu_addr), .cpu_din(cpu_din),
        .iorq_n(iorq_n), .mreq_n(mreq_n), .rd_n(rd_n), .wr_n(wr_n),
        .slot_en(slot_en), .ram_addr(ram_addr), .ram_cs(ram_cs),
        .rd_data(rd_data), .rd_oe(rd_oe)
    );

    mmap_top #(.BANK_W(5)) dut5_i (
        .clk(clk), .rst(rst), .cpu_addr(cpu_addr), .cpu_din(cpu_din),
        .iorq_n(iorq_n), .mreq_n(mreq_n), .rd_n(rd_n), .wr_n(wr_n),
        .slot_en(slot_en), .ram_addr(ram_addr5), .ram_cs(ram_cs5),
        .rd_data(rd_data5), .rd_oe(rd_oe5)
    );

    task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s got %h exp %h", tag, got, exp);
        end
    endtask

    function automatic logic port_match(input logic [15:0] a);
        return a[7:2] == 6'b111111;
    endfunction

    task automatic idle();
        iorq_n = 1'b1; mreq_n = 1'b1; rd_n = 1'b1; wr_n = 1'b1;
    endtask

    // one bus cycle of arbitrary strobes; model updated by requirement R2/R6
    task automatic io_cycle(input logic [15:0] a, input logic [7:0] d,
                            input logic iq, input logic w, input logic s);
        @(negedge clk);
        cpu_addr = a; cpu_din = d; iorq_n = iq; wr_n = w; rd_n = 1'b1;
        mreq_n = 1'b1; slot_en = s;
        @(negedge clk);
        if (!iq && !w && port_match(a)) mdl[a[1:0]] = d;
        idle();
    endtask

    task automatic io_wr(input logic [15:0] a, input logic [7:0] d, input logic s);
        io_cycle(a, d, 1'b0, 1'b0, s);
    endtask

    // translate check for page p on both instances (R3, R9)
    task automatic chk_map(input string tag, input int p, input logic [13:0] ofs);
        cpu_addr = {2'(p), ofs}; mreq_n = 1'b0; slot_en = 1'b1;
        #1;
        chk(tag, 32'(ram_addr), 32'({mdl[p], ofs}));
        chk({tag, "/R9"}, 32'(ram_addr5), 32'({mdl[p][4:0], ofs}));
        idle();
    endtask

    task automatic chk_all(input string tag);
        for (int p = 0; p < 4; p++) chk_map(tag, p, 14'($urandom));
    endtask

    task automatic chk_read(input string tag, input logic [15:0] a);
        cpu_addr = a; iorq_n = 1'b0; rd_n = 1'b0;
        #1;
        if (port_match(a)) begin
            chk({tag, " oe"}, 32'(rd_oe), 32'd1);
            chk(tag, 32'(rd_data), 32'(mdl[a[1:0]]));
            chk({tag, "/R9"}, 32'(rd_data5), 32'({3'b111, mdl[a[1:0]][4:0]}));
        end else begin
            chk({tag, " oe"}, 32'(rd_oe), 32'd0);
        end
        idle();
    endtask

    initial begin
        process::self().srandom(32'h5eed_0042);
        repeat (3) @(negedge clk);
        rst = 1'b0;
        for (int p = 0; p < 4; p++) mdl[p] = 8'(3 - p);

        // R1 reset banks
        @(negedge clk);
        chk_all("R1 reset map");
        for (int p = 0; p < 4; p++) chk_read("R1 reset readback", 16'h00FC + 16'(p));

        // R8 chip select qualification
        cpu_addr = 16'h4000; mreq_n = 1'b0; slot_en = 1'b0; #1;
        chk("R8 slot off", 32'(ram_cs), 32'd0);
        mreq_n = 1'b1; slot_en = 1'b1; #1;
        chk("R8 no mreq", 32'(ram_cs), 32'd0);
        mreq_n = 1'b0; #1;
        chk("R8 active", 32'(ram_cs), 32'd1);
        idle();

        // R2 each port, others kept
        io_wr(16'h00FC, 8'hA1, 1'b1);
        io_wr(16'h00FD, 8'h5B, 1'b1);
        io_wr(16'h00FE, 8'hFF, 1'b1);
        io_wr(16'h00FF, 8'h00, 1'b1);
        chk_all("R2 per-page write");

        // R4 upper address byte ignored
        io_wr(16'hA5FE, 8'h3C, 1'b1);
        io_wr(16'h12FC, 8'hC3, 1'b1);
        chk_all("R4 upper byte ignored");

        // R5 write with slot disabled
        io_wr(16'h00FF, 8'h77, 1'b0);
        chk_all("R5 slot_en low write");

        // R6 near misses
        io_cycle(16'h00FC, 8'h11, 1'b0, 1'b1, 1'b1);
        io_cycle(16'h00FD, 8'h22, 1'b1, 1'b0, 1'b1);
        io_cycle(16'h00FB, 8'h33, 1'b0, 1'b0, 1'b1);
        io_cycle(16'h007C, 8'h44, 1'b0, 1'b0, 1'b1);
        io_cycle(16'hFCFD, 8'h55, 1'b1, 1'b1, 1'b1);
        chk_all("R6 no stray write");

        // R7 readback and misses
        for (int p = 0; p < 4; p++) chk_read("R7 readback", 16'hBE00 | 16'h00FC | 16'(p));
        chk_read("R7 miss FB", 16'h00FB);
        chk_read("R7 miss 7D", 16'h007D);

        // R9 narrow truncation with upper bits set
        io_wr(16'h00FD, 8'hE9, 1'b1);
        chk_map("R9 narrow", 1, 14'h2AAA);
        chk_read("R9 narrow rb", 16'h00FD);

        // random mix
        for (int i = 0; i < 400; i++) begin
            int op;
            logic [15:0] a;
            op = int'($urandom_range(0, 3));
            a  = 16'($urandom);
            if (op == 0) a[7:2] = 6'b111111;
            case (op)
                0, 1: io_cycle(a, 8'($urandom), 1'($urandom), 1'($urandom), 1'($urandom));
                2:    chk_map("R3 random map", int'($urandom_range(0, 3)), 14'($urandom));
                default: chk_read("R7 random read", {8'($urandom), 6'b111111, 2'($urandom)});
            endcase
        end

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog got timeout exp finish");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule